// File: doc/BRIEF.md
# ADC Output Coding and Overflow Stage

This stage sits between the conversion core of a 16-bit sampling converter and the parallel output pins. At the end of every conversion it takes the core's straight-binary result together with two range flags and forms the final output word. The word can be presented as straight binary, offset binary or two's complement, or as the bitwise complement of any of these. The stage also raises an overflow flag, drives a second copy of the most significant bit and produces the drive enable for the external three-state output register.

The coding select, the format select and the active-low output enable are sampled only while no conversion is running. A request that arrives while end-of-conversion is high is held back and takes effect on the clock edge where end-of-conversion is first seen low again. A start pulse that arrives during a conversion restarts the core. The result that then comes out is flagged invalid.

The tristate pad and its pull-up on the coding-select pin sit outside this block. Reset loads true coding with the outputs disabled, which stands in for the pulled-up, undriven state.

Top module: `adc_out_coder`

## Requirements
- R1: After reset, data_o is 0, ovf_o is 0, word_ok_o is 0 and bus_en_o is 0. This reset state is kept while end_conv_i stays high, whatever the control inputs do.
- R2: A result is captured on the first rising clock edge at which end_conv_i is sampled 0 after having been 1. It appears on the outputs after that edge and is held unchanged until the next such edge.
- R3: With the applied comp_n 0, all 16 data bits and msb_dup_o are inverted. With comp_n 1 they pass unchanged. msb_dup_o always equals data_o[15].
- R4: With the applied twos_fmt 1, bit 15 of the word is inverted before any complementing. This turns offset binary into two's complement.
- R5: When above_i is 1, the stored code is all ones and the overflow flag is 1. When below_i is 1, or the raw result is 0, the stored code is all zeros and the overflow flag is 1. Otherwise the overflow flag is 0. above_i takes priority over below_i.
- R6: Under complementing, the overflow cases are reversed on the bus. Above-range shows all zeros with ovf_o 1, and an all-ones raw result shows all zeros with ovf_o 0.
- R7: bus_en_o is 1 when the applied active-low enable is 0, and bus_en_o is 0 when that enable is 1.
- R8: While end_conv_i is high, changes on comp_n_i, twos_i and oe_ni have no effect. At other times a change is applied on the next rising edge. A change held during a conversion is applied on the edge that captures the result.
- R9: A start_i pulse sampled while end_conv_i is high makes the next captured result carry word_ok_o 0. An ordinary conversion gives word_ok_o 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 16 | Straight-binary result from the conversion core |
| above_i | input | 1 | Input above the all-ones level |
| below_i | input | 1 | Input below the all-zeros level |
| end_conv_i | input | 1 | High while a conversion is in progress |
| start_i | input | 1 | Start-convert pulse |
| comp_n_i | input | 1 | 0 selects complemented coding |
| twos_i | input | 1 | 1 inverts the word MSB (two's complement) |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 16 | Coded output word |
| msb_dup_o | output | 1 | Second copy of the output MSB |
| ovf_o | output | 1 | Overflow flag |
| word_ok_o | output | 1 | Captured result is valid |
| bus_en_o | output | 1 | Drive enable for the three-state register |

## Verification
The assertions assume that end_conv_i is a clean level from the core, synchronous to clk_i, and that above_i and below_i are settled on the edge where end_conv_i falls. The stimulus changes all inputs only on falling clock edges. It keeps raw_i and the range flags fixed through each conversion, and it raises start_i during a conversion only in the restart case. It never asserts above_i and below_i together except where the priority rule is being checked.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;
  typedef struct packed {
    logic comp_n;
    logic twos;
    logic oe_n;
  } out_ctrl_t;

  localparam out_ctrl_t CTRL_RST = '{comp_n: 1'b1, twos: 1'b0, oe_n: 1'b1};
endpackage

// File: rtl/adc_ctrl_hold.sv
module adc_ctrl_hold
  import adc_out_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      end_conv_i,
  input  out_ctrl_t req_i,
  output out_ctrl_t ctrl_o
);
  out_ctrl_t ctrl_q;

  // requests pass only while no conversion runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ctrl_q <= CTRL_RST;
    else if (!end_conv_i) ctrl_q <= req_i;
  end

  assign ctrl_o = ctrl_q;

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_conv_i |=> $stable(ctrl_q));

  p_apply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_conv_i |=> (ctrl_q == $past(req_i)));
endmodule

// File: rtl/adc_result_cap.sv
module adc_result_cap #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_conv_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic              above_i,
  input  logic              below_i,
  output logic [DATA_W-1:0] code_o,
  output logic              ovf_o,
  output logic              ok_o,
  output logic              done_o
);
  logic              eoc_q, taint_q, ok_q, ovf_q;
  logic [DATA_W-1:0] code_q, code_d;
  logic              ovf_d, fall;

  assign fall = eoc_q & ~end_conv_i;

  always_comb begin
    if (above_i)      code_d = '1;
    else if (below_i) code_d = '0;
    else              code_d = raw_i;
    ovf_d = above_i | below_i | (raw_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_q   <= 1'b0;
      taint_q <= 1'b0;
      ok_q    <= 1'b0;
      ovf_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      eoc_q <= end_conv_i;
      if (fall) begin
        code_q  <= code_d;
        ovf_q   <= ovf_d;
        ok_q    <= ~taint_q;
        taint_q <= 1'b0;
      end else if (start_i && end_conv_i) begin
        taint_q <= 1'b1;  // restart: this conversion's result is invalid
      end
    end
  end

  assign code_o = code_q;
  assign ovf_o  = ovf_q;
  assign ok_o   = ok_q;
  assign done_o = fall;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eoc_q && !end_conv_i) |=> ($stable(code_q) && $stable(ovf_q)));

  p_ok_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_conv_i |=> $stable(ok_q));
endmodule

// File: rtl/adc_word_coder.sv
module adc_word_coder
  import adc_out_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] code_i,
  input  out_ctrl_t         ctrl_i,
  output logic [DATA_W-1:0] word_o,
  output logic              msb_o,
  output logic              en_o
);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] fmt_w;

  assign fmt_w  = ctrl_i.twos ? (code_i ^ MSB_MASK) : code_i;
  assign word_o = ctrl_i.comp_n ? fmt_w : ~fmt_w;
  assign msb_o  = ctrl_i.comp_n ? fmt_w[DATA_W-1] : ~fmt_w[DATA_W-1];
  assign en_o   = ~ctrl_i.oe_n;
endmodule

// File: rtl/adc_out_coder.sv
module adc_out_coder
  import adc_out_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] raw_i,
  input  logic              above_i,
  input  logic              below_i,
  input  logic              end_conv_i,
  input  logic              start_i,
  input  logic              comp_n_i,
  input  logic              twos_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              msb_dup_o,
  output logic              ovf_o,
  output logic              word_ok_o,
  output logic              bus_en_o
);
  out_ctrl_t         req, ctrl;
  logic [DATA_W-1:0] code;
  logic              done;

  assign req = '{comp_n: comp_n_i, twos: twos_i, oe_n: oe_ni};

  adc_ctrl_hold i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .end_conv_i (end_conv_i),
    .req_i      (req),
    .ctrl_o     (ctrl)
  );

  adc_result_cap #(.DATA_W(DATA_W)) i_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .end_conv_i (end_conv_i),
    .start_i    (start_i),
    .raw_i      (raw_i),
    .above_i    (above_i),
    .below_i    (below_i),
    .code_o     (code),
    .ovf_o      (ovf_o),
    .ok_o       (word_ok_o),
    .done_o     (done)
  );

  adc_word_coder #(.DATA_W(DATA_W)) i_coder (
    .code_i (code),
    .ctrl_i (ctrl),
    .word_o (data_o),
    .msb_o  (msb_dup_o),
    .en_o   (bus_en_o)
  );

  p_dup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msb_dup_o == data_o[DATA_W-1]);

  p_en_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_conv_i && !done) |=> $stable(bus_en_o));
endmodule

// File: tb/test_adc_out_coder.sv
module test_adc_out_coder;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] data;
    logic        msb, ovf, ok, en;
    string       req;
  } exp_t;

  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] raw_i = 16'h1234;
  logic        above_i = 0, below_i = 0, end_conv_i = 1, start_i = 0;
  logic        comp_n_i = 1, twos_i = 0, oe_ni = 0;
  logic [15:0] data_o;
  logic        msb_dup_o, ovf_o, word_ok_o, bus_en_o;

  int   total = 0, bad = 0;
  bit   s_comp_n = 1, s_twos = 0, s_oe_n = 0;
  exp_t sb[$];
  event sample_ev;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_out_coder i_adc_out_coder (
    .clk_i, .rst_ni, .raw_i, .above_i, .below_i, .end_conv_i, .start_i,
    .comp_n_i, .twos_i, .oe_ni, .data_o, .msb_dup_o, .ovf_o, .word_ok_o, .bus_en_o
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [15:0] raw, logic ab, logic bl, logic ok, string req);
    exp_t e;
    logic [15:0] c;
    c = ab ? 16'hffff : (bl ? 16'h0000 : raw);
    if (s_twos) c[15] = ~c[15];
    if (!s_comp_n) c = ~c;
    e.data = c; e.msb = c[15];
    e.ovf = ab | bl | (raw == 16'h0);
    e.ok = ok; e.en = ~s_oe_n; e.req = req;
    return e;
  endfunction

  task automatic set_ctrl(bit cn, bit tw, bit on);
    @(negedge clk_i);
    comp_n_i = cn; twos_i = tw; oe_ni = on;
    s_comp_n = cn; s_twos = tw; s_oe_n = on;
    @(negedge clk_i);
  endtask

  task automatic convert(logic [15:0] raw, logic ab, logic bl, bit restart, string req);
    sb.push_back(model(raw, ab, bl, !restart, req));
    @(negedge clk_i);
    end_conv_i = 1; raw_i = raw; above_i = ab; below_i = bl;
    repeat (2) @(negedge clk_i);
    if (restart) begin
      start_i = 1;
      @(negedge clk_i);
      start_i = 0;
    end
    repeat (2) @(negedge clk_i);
    end_conv_i = 0;
    @(negedge clk_i);
    -> sample_ev;
  endtask

  // monitor: compare as each result appears
  initial forever begin
    exp_t e;
    @(sample_ev);
    e = sb.pop_front();
    chk(e.req, "data", data_o, e.data);
    chk(e.req, "msb_dup", {15'b0, msb_dup_o}, {15'b0, e.msb});
    chk(e.req, "ovf", {15'b0, ovf_o}, {15'b0, e.ovf});
    chk(e.req, "word_ok", {15'b0, word_ok_o}, {15'b0, e.ok});
    chk(e.req, "bus_en", {15'b0, bus_en_o}, {15'b0, e.en});
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    // R1: reset state, kept while end_conv_i high (R8: oe_ni=0 not yet applied)
    chk("R1", "data", data_o, 16'h0);
    chk("R1", "ovf", {15'b0, ovf_o}, 16'h0);
    chk("R1", "word_ok", {15'b0, word_ok_o}, 16'h0);
    chk("R8", "bus_en frozen", {15'b0, bus_en_o}, 16'h0);
    sb.push_back(model(16'h1234, 0, 0, 1, "R2"));
    end_conv_i = 0;
    @(negedge clk_i);
    -> sample_ev;

    convert(16'h8001, 0, 0, 0, "R2");
    set_ctrl(0, 0, 0);
    convert(16'h8001, 0, 0, 0, "R3");
    set_ctrl(1, 1, 0);
    convert(16'h0005, 0, 0, 0, "R4");
    set_ctrl(0, 1, 0);
    convert(16'h8000, 0, 0, 0, "R4");
    set_ctrl(1, 0, 0);
    convert(16'h1234, 1, 0, 0, "R5");
    convert(16'h1234, 0, 1, 0, "R5");
    convert(16'h0000, 0, 0, 0, "R5");
    convert(16'hffff, 0, 0, 0, "R5");
    convert(16'h0042, 1, 1, 0, "R5");
    set_ctrl(0, 0, 0);
    convert(16'h1234, 1, 0, 0, "R6");
    convert(16'hffff, 0, 0, 0, "R6");
    set_ctrl(1, 0, 1);
    convert(16'h4321, 0, 0, 0, "R7");
    set_ctrl(1, 0, 0);
    convert(16'h2222, 0, 0, 1, "R9");
    convert(16'h00ff, 0, 0, 0, "R9");

    // R8: idle change applies on the next edge
    set_ctrl(0, 0, 0);
    chk("R8", "idle comp", data_o, 16'hff00);

    // R8: change during conversion is held until the capture edge
    @(negedge clk_i);
    end_conv_i = 1; raw_i = 16'h0f0f;
    @(negedge clk_i);
    comp_n_i = 1; oe_ni = 1;
    repeat (3) @(negedge clk_i);
    chk("R8", "held data", data_o, 16'hff00);
    chk("R8", "held bus_en", {15'b0, bus_en_o}, 16'h1);
    s_comp_n = 1; s_oe_n = 1;
    sb.push_back(model(16'h0f0f, 0, 0, 1, "R8"));
    end_conv_i = 0;
    @(negedge clk_i);
    -> sample_ev;
    @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule